// File: doc/BRIEF.md
# Command-Driven JTAG Shift Engine

This block turns a stream of command bytes into JTAG pin activity. A host-side FIFO presents bytes through a valid/ready pair. Each command is an opcode byte, then a 16-bit length, then the payload bytes to send. The engine drives TCK, TMS and TDI and samples TDO. Flags in the opcode pick the line being driven, the bit order, bit or byte granularity, and which TCK edge launches outputs and which edge samples TDO.

Sampled TDO bits are gathered into bytes and handed to a read-back FIFO through a one-entry valid/ready output. TCK comes from a programmable divider of the system clock. It stops, and holds its level, whenever the engine is waiting for a payload byte or the read-back side is not accepting. A state-walk command sends a few TMS bits. Its payload bit 7 sits on TDI, so the last data bit can go out as the controller leaves a shift state.

Top module: `jtag_cmd_engine`

## Requirements
- R1: After reset, tck_o=0, tms_o=1, tdi_o=0, rsp_valid_o=0 and cmd_ready_o=1.
- R2: A command is one opcode byte, then the length low byte, then the length high byte, then payload bytes only if opcode bit 4 or bit 6 is set. The length holds count minus one. In byte mode (opcode bit 1 clear) it counts payload bytes, up to 65536. A command with neither write flag takes no payload.
- R3: Exactly one TCK pulse is produced per shifted bit. Byte mode gives 8 per byte. Bit mode (opcode bit 1 set) gives length[2:0]+1 bits taken from a single payload byte.
- R4: Opcode bit 3 set means LSB first: shifted bit i is payload bit i, and sampled bit i is stored in read-back bit i. Bit 3 clear uses position 7-i for both. Read-back positions not sampled are 0.
- R5: Opcode bit 0 set means the driven line takes its new value while TCK is low, before the rising edge. Bit 0 clear means it changes together with the rising edge. In both cases TMS and TDI stay steady while TCK is high.
- R6: Opcode bit 2 set samples TDO at the falling TCK edge. Bit 2 clear samples it at the rising edge.
- R7: Opcode bit 4 drives payload bits onto TDI. Bit 6 drives them onto TMS, and during that command TDI holds bit 7 of the current payload byte. A line that is not driven keeps its value.
- R8: An opcode with both bit 4 and bit 6 set is dropped with no TCK activity, and the next byte is taken as a new opcode.
- R9: With opcode bit 5 set, a read-back byte is offered after every 8 sampled bits or after the final partial group. With bit 5 clear, nothing is offered. An offered byte holds until it is accepted.
- R10: Each TCK half period lasts div_i+1 system clock cycles.
- R11: TCK holds its level while a read-back byte waits unaccepted. While a payload byte is awaited, TCK rests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | TCK half period minus one, in clock cycles |
| cmd_data_i | input | 8 | Command stream byte |
| cmd_valid_i | input | 1 | Command byte present |
| cmd_ready_o | output | 1 | Command byte accepted this cycle if valid |
| rsp_data_o | output | 8 | Captured TDO byte |
| rsp_valid_o | output | 1 | Captured byte present |
| rsp_ready_i | input | 1 | Read-back side accepts the byte |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |

## Verification
A wrong parser state shows up as stray TCK pulses or as bytes taken at the wrong time. A length or opcode byte read as payload moves every later pin value, and this is seen at the first rising edge of the next bit. Bit index or order faults show as a wrong TMS or TDI value during that same high phase, or as a wrong read-back byte at the falling edge that closes the group. Divider and stall faults show within one half period, as a high phase of the wrong length or as TCK moving while a byte is held.

// File: rtl/jce_pkg.sv
package jce_pkg;
  localparam int unsigned LEN_W = 16;  // two length bytes

  // opcode bits 6..0
  typedef struct packed {
    logic wr_tms;
    logic rd_tdo;
    logic wr_tdi;
    logic lsb_first;
    logic rd_fall;
    logic bit_mode;
    logic wr_fall;
  } jce_op_t;

  typedef enum logic [2:0] {
    S_OP, S_LEN0, S_LEN1, S_LOAD, S_SHIFT
  } jce_state_e;

  function automatic logic [2:0] bit_pos(input logic lsb, input logic [2:0] idx);
    return lsb ? idx : 3'd7 - idx;
  endfunction
endpackage

// File: rtl/jce_tck_gen.sv
module jce_tck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/jce_capture.sv
module jce_capture (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       smp_i,
  input  logic [2:0] pos_i,
  input  logic       tdo_i,
  output logic [7:0] byte_nx_o
);
  logic [7:0] cap_q;

  always_comb begin
    byte_nx_o = cap_q;
    if (smp_i) byte_nx_o[pos_i] = tdo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (clr_i) cap_q <= '0;
    else            cap_q <= byte_nx_o;
  end
endmodule

// File: rtl/jtag_cmd_engine.sv
module jtag_cmd_engine
  import jce_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       cmd_data_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  output logic [7:0]       rsp_data_o,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  input  logic             tdo_i
);
  jce_state_e       state_q;
  jce_op_t          op_q, op_in;
  logic [7:0]       len_lo_q, data_q, rsp_data_q;
  logic [LEN_W-1:0] byte_cnt_q;
  logic [2:0]       last_idx_q, bit_idx_q, pos, pos_nx, pos0;
  logic             tck_q, tms_q, tdi_q, rsp_valid_q;
  logic             wr_any, rsp_stall, tick, rise, fall, smp, byte_end, load_go;
  logic [7:0]       load_byte, cap_nx;

  assign op_in     = jce_op_t'(cmd_data_i[6:0]);
  assign wr_any    = op_q.wr_tdi | op_q.wr_tms;
  assign rsp_stall = rsp_valid_q & ~rsp_ready_i;
  assign rise      = tick & ~tck_q;
  assign fall      = tick & tck_q;
  assign smp       = op_q.rd_tdo & (op_q.rd_fall ? fall : rise);
  assign byte_end  = fall && (bit_idx_q == last_idx_q);
  assign load_go   = (state_q == S_LOAD) && (!wr_any || cmd_valid_i);
  assign load_byte = wr_any ? cmd_data_i : 8'h00;
  assign pos       = bit_pos(op_q.lsb_first, bit_idx_q);
  assign pos_nx    = bit_pos(op_q.lsb_first, bit_idx_q + 3'd1);
  assign pos0      = bit_pos(op_q.lsb_first, 3'd0);

  assign cmd_ready_o = (state_q == S_OP) || (state_q == S_LEN0) || (state_q == S_LEN1) ||
                       ((state_q == S_LOAD) && wr_any);

  jce_tck_gen #(.DIV_W(DIV_W)) i_tck_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != S_SHIFT),
    .en_i   ((state_q == S_SHIFT) && !rsp_stall),
    .div_i  (div_i),
    .tick_o (tick)
  );

  jce_capture i_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load_go),
    .smp_i     (smp),
    .pos_i     (pos),
    .tdo_i     (tdo_i),
    .byte_nx_o (cap_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_OP;
      op_q        <= '0;
      len_lo_q    <= '0;
      byte_cnt_q  <= '0;
      last_idx_q  <= '0;
      bit_idx_q   <= '0;
      data_q      <= '0;
      tck_q       <= 1'b0;
      tms_q       <= 1'b1;
      tdi_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready_i) rsp_valid_q <= 1'b0;
      unique case (state_q)
        S_OP: if (cmd_valid_i) begin
          op_q <= op_in;
          if (!(op_in.wr_tdi && op_in.wr_tms)) state_q <= S_LEN0;  // both lines: drop
        end
        S_LEN0: if (cmd_valid_i) begin
          len_lo_q <= cmd_data_i;
          state_q  <= S_LEN1;
        end
        S_LEN1: if (cmd_valid_i) begin
          byte_cnt_q <= op_q.bit_mode ? '0 : {cmd_data_i, len_lo_q};
          last_idx_q <= op_q.bit_mode ? len_lo_q[2:0] : 3'd7;
          state_q    <= S_LOAD;
        end
        S_LOAD: if (load_go) begin
          data_q    <= load_byte;
          bit_idx_q <= '0;
          if (op_q.wr_tms) tdi_q <= load_byte[7];
          if (op_q.wr_fall) begin
            if (op_q.wr_tdi) tdi_q <= load_byte[pos0];
            if (op_q.wr_tms) tms_q <= load_byte[pos0];
          end
          state_q <= S_SHIFT;
        end
        S_SHIFT: begin
          if (rise) begin
            tck_q <= 1'b1;
            if (!op_q.wr_fall) begin
              if (op_q.wr_tdi) tdi_q <= data_q[pos];
              if (op_q.wr_tms) tms_q <= data_q[pos];
            end
          end
          if (fall) begin
            tck_q <= 1'b0;
            if (byte_end) begin
              if (op_q.rd_tdo) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= cap_nx;
              end
              if (byte_cnt_q == '0) state_q <= S_OP;
              else begin
                byte_cnt_q <= byte_cnt_q - LEN_W'(1);
                state_q    <= S_LOAD;
              end
            end else begin
              bit_idx_q <= bit_idx_q + 3'd1;
              if (op_q.wr_fall) begin
                if (op_q.wr_tdi) tdi_q <= data_q[pos_nx];
                if (op_q.wr_tms) tms_q <= data_q[pos_nx];
              end
            end
          end
        end
        default: state_q <= S_OP;
      endcase
    end
  end

  assign tck_o       = tck_q;
  assign tms_o       = tms_q;
  assign tdi_o       = tdi_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/jce_checker.sv
module jce_checker #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] div_i,
  input logic             tck_o,
  input logic             tms_o,
  input logic             tdi_o,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [7:0]       rsp_data_o,
  input logic             idle_i
);
  // R11
  tck_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> $stable(tck_o));

  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  // R9
  rsp_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $fell(tck_o));

  // R5
  pins_steady_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && $past(tck_o)) |-> ($stable(tdi_o) && $stable(tms_o)));

  // R10
  half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((div_i != '0) && (tck_o != $past(tck_o))) |=> $stable(tck_o));

  // R3
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !tck_o);
endmodule

bind jtag_cmd_engine jce_checker #(.DIV_W(DIV_W)) i_jce_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .div_i       (div_i),
  .tck_o       (tck_o),
  .tms_o       (tms_o),
  .tdi_o       (tdi_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_data_o  (rsp_data_o),
  .idle_i      (state_q == jce_pkg::S_OP)
);

// File: tb/test_jtag_cmd_engine.sv
module test_jtag_cmd_engine;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [DIV_W-1:0] div_r = '0;
  logic [7:0] cmd_data = '0;
  logic cmd_valid = 1'b0, rsp_rdy = 1'b1, tdo = 1'b0;
  logic cmd_ready_o, rsp_valid_o, tck_o, tms_o, tdi_o;
  logic [7:0] rsp_data_o;

  jtag_cmd_engine #(.DIV_W(DIV_W)) i_jtag_cmd_engine (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div_r),
    .cmd_data_i(cmd_data), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready_o),
    .rsp_data_o(rsp_data_o), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_rdy),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  logic [2:0] pin_q[$];   // {tms, tdi, line before rise}
  logic [7:0] rsp_q[$];
  logic ta[64], tb[64];
  int tidx = 0, rises = 0, edges = 0, rise_cyc = 0;
  logic prev_tck = 1'b0, prev_tdi = 1'b0, prev_tms = 1'b1;
  logic sel_tms = 1'b0, chk_per = 1'b0;
  logic m_tms = 1'b1, m_tdi = 1'b0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // pin monitor / target model, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (tck_o && !prev_tck) begin
        rises++; edges++; rise_cyc = cyc;
        if (pin_q.size() == 0) check(0, cur_req, "unexpected TCK pulse", 1, 0);
        else begin
          logic [2:0] e;
          logic pre;
          e = pin_q.pop_front();
          pre = sel_tms ? prev_tms : prev_tdi;
          check(tms_o == e[2], cur_req, "tms in high phase", tms_o, e[2]);
          check(tdi_o == e[1], cur_req, "tdi in high phase", tdi_o, e[1]);
          check(pre == e[0], "R5", "line before rising edge", pre, e[0]);
        end
        tdo = tb[tidx];
      end else if (!tck_o && prev_tck) begin
        edges++;
        if (chk_per) check(cyc - rise_cyc == int'(div_r) + 1, "R10", "high phase cycles",
                           cyc - rise_cyc, int'(div_r) + 1);
        if (tidx < 63) tidx++;
        tdo = ta[tidx];
      end
      if (rsp_valid_o && rsp_rdy) begin
        if (rsp_q.size() == 0) check(0, "R9", "unexpected read-back byte", rsp_data_o, 0);
        else begin
          logic [7:0] r;
          r = rsp_q.pop_front();
          check(rsp_data_o == r, "R9", {cur_req, " read-back byte"}, rsp_data_o, r);
        end
      end
      prev_tck = tck_o; prev_tdi = tdi_o; prev_tms = tms_o;
    end
  end

  task automatic push_byte(input logic [7:0] b);
    bit acc;
    cmd_data = b; cmd_valid = 1'b1;
    do begin
      acc = cmd_ready_o;
      @(negedge clk);
    end while (!acc);
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [15:0] len,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input int gap, input string req);
    logic [7:0] dat[3];
    logic bm, wf, rf, lsb, wtdi, rd, wtms, prevline, dbit, pre;
    int nby, nbit, k, r0, e0;
    dat[0] = d0; dat[1] = d1; dat[2] = d2;
    wf = op[0]; bm = op[1]; rf = op[2]; lsb = op[3]; wtdi = op[4]; rd = op[5]; wtms = op[6];
    nby  = bm ? 1 : int'(len) + 1;
    nbit = bm ? int'(len[2:0]) + 1 : 8;
    cur_req = req; sel_tms = wtms; tidx = 0;
    for (int j = 0; j < 64; j++) begin
      ta[j] = ((j * 7 + int'(op) + int'(len)) % 5) < 2;
      tb[j] = ~ta[j];
    end
    tdo = ta[0];
    k = 0;
    for (int b = 0; b < nby; b++) begin
      logic [7:0] rb;
      rb = '0;
      if (wtms) m_tdi = dat[b][7];
      for (int i = 0; i < nbit; i++) begin
        int pos;
        pos = lsb ? i : 7 - i;
        dbit = (wtdi || wtms) ? dat[b][pos] : 1'b0;
        prevline = wtms ? m_tms : m_tdi;
        if (wtdi) m_tdi = dbit;
        if (wtms) m_tms = dbit;
        pre = (wf && (wtdi || wtms)) ? dbit : prevline;
        pin_q.push_back({m_tms, m_tdi, pre});
        rb[pos] = rf ? tb[k] : ta[k];
        k++;
      end
      if (rd) rsp_q.push_back(rb);
    end
    r0 = rises; e0 = edges;
    push_byte(op); push_byte(len[7:0]); push_byte(len[15:8]);
    if (wtdi || wtms)
      for (int b = 0; b < nby; b++) begin
        if (b == 1 && gap > 0) begin
          while (edges - e0 < 2 * nbit) @(negedge clk);
          repeat (gap) @(negedge clk);
          // R11: waiting for payload, TCK rests low
          check(edges - e0 == 2 * nbit && !tck_o, "R11", "edges while awaiting payload",
                edges - e0, 2 * nbit);
        end
        push_byte(dat[b]);
      end
    while (pin_q.size() != 0 || rsp_q.size() != 0) @(negedge clk);
    repeat (2 * (int'(div_r) + 3)) @(negedge clk);
    // R3: one pulse per bit
    check(rises - r0 == nby * nbit, "R3", {req, " TCK pulse count"}, rises - r0, nby * nbit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(tck_o == 1'b0, "R1", "tck", tck_o, 0);
    check(tms_o == 1'b1, "R1", "tms", tms_o, 1);
    check(tdi_o == 1'b0, "R1", "tdi", tdi_o, 0);
    check(rsp_valid_o == 1'b0, "R1", "rsp_valid", rsp_valid_o, 0);
    check(cmd_ready_o == 1'b1, "R1", "cmd_ready", cmd_ready_o, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R5 R6: TDI bytes, LSB first, fall-write, rise-read
    run_cmd(8'h39, 16'd1, 8'hA5, 8'h3C, 8'h00, 0, "R2");
    // R4 R6: MSB first, rise-write, fall-read, three bytes
    div_r = 8'd1;
    run_cmd(8'h34, 16'd2, 8'h81, 8'h5E, 8'hF0, 0, "R4");
    // R3 R9: bit mode, 5 bits, partial read-back
    div_r = 8'd0;
    run_cmd(8'h3F, 16'd4, 8'h16, 8'h00, 8'h00, 0, "R3");
    // R4: bit mode MSB first, 3 bits
    run_cmd(8'h32, 16'd2, 8'hA0, 8'h00, 8'h00, 0, "R4");
    // R7: TMS walk, TDI carries payload bit 7, no read-back
    run_cmd(8'h4B, 16'd6, 8'h9F, 8'h00, 8'h00, 0, "R7");
    // R7 R6: TMS walk with capture, rise-write
    run_cmd(8'h6A, 16'd3, 8'h05, 8'h00, 8'h00, 0, "R7");

    // R8: both line flags, opcode dropped
    begin
      int e0;
      e0 = edges;
      push_byte(8'h50);
      repeat (10) @(negedge clk);
      check(edges == e0, "R8", "TCK edges after dropped opcode", edges - e0, 0);
      check(cmd_ready_o == 1'b1, "R8", "ready for new opcode", cmd_ready_o, 1);
    end
    run_cmd(8'h19, 16'd0, 8'hC3, 8'h00, 8'h00, 0, "R8");

    // R2: read-only, no payload consumed, TDI held
    run_cmd(8'h2C, 16'd0, 8'h00, 8'h00, 8'h00, 0, "R2");

    // R10: divider
    div_r = 8'd5; chk_per = 1'b1;
    run_cmd(8'h18, 16'd0, 8'h6B, 8'h00, 8'h00, 0, "R10");
    div_r = 8'd2;
    run_cmd(8'h3D, 16'd1, 8'h4E, 8'h00, 8'h00, 0, "R10");
    chk_per = 1'b0;

    // R11: payload gap
    run_cmd(8'h39, 16'd1, 8'h12, 8'hEF, 8'h00, 20, "R11");

    // R11: read-back held off
    div_r = 8'd0;
    rsp_rdy = 1'b0;
    fork
      run_cmd(8'h39, 16'd1, 8'h77, 8'hC8, 8'h00, 0, "R11");
      begin
        int e1;
        while (!rsp_valid_o) @(negedge clk);
        @(negedge clk);
        e1 = edges;
        repeat (30) @(negedge clk);
        check(edges == e1, "R11", "TCK edges while read-back held", edges - e1, 0);
        check(rsp_valid_o == 1'b1, "R9", "byte held until accepted", rsp_valid_o, 1);
        rsp_rdy = 1'b1;
      end
    join

    report();
    $finish;
  end
endmodule